// File: doc/BRIEF.md
# Serial Management Register Responder

This block is the slave end of a two-wire management link of the clause-22 kind, where software toggles a clock line and a data line by hand. Every rising edge of the management clock delivers one bit. The block follows the frame through a fixed sequence: idle, a start pair, a two-bit operation code, a five-bit PHY address, a five-bit register address, a turnaround, and sixteen data bits. A write places the data word into a table of thirty-two 16-bit registers. A read sends the selected word back one bit per clock edge, most significant bit first.

A few register indices return hard-wired identity and capability words, whatever is stored there. Register 0 returns its stored word with some bits overridden. A malformed start or operation code sends the frame tracker back to its reset state straight away, so the next valid frame can follow with no idle bits in between. The three host-side inputs pass through a common synchronizer before any edge is detected, so they may be driven from a slow, unrelated software clock.

Top module: `mdio_responder`

## Requirements
- R1: A bit is taken only when the synchronized `mdc` goes from 0 to 1. Changes on `mdio_in` or `host_drive` while `mdc` holds steady alter neither the frame progress nor `mdio_out`.
- R2: At a clock edge, the data value comes from `mdio_in` only when `host_drive` is 1. When `host_drive` is 0, the bit taken at the previous edge is used again.
- R3: From reset or idle, a 0 bit starts a frame, and a 1 bit keeps the block idle. The bit after the starting 0 must be 1; a 0 there returns the block to reset at once.
- R4: The operation code is the next two bits in time order: 1 then 0 means read, and 0 then 1 means write. A pair of 00 or 11 returns the block to reset at once.
- R5: After the operation code come 5 PHY-address bits and then 5 register-address bits, both MSB first. The PHY address is consumed but not decoded, so all PHY addresses share one 32-entry table.
- R6: A write frame has 2 turnaround edges followed by 16 data edges, MSB first. The word is stored on the last data edge.
- R7: A read frame has 1 turnaround edge. On the first data edge the block latches the register view. After each of the 16 data edges, `mdio_out` carries the next bit, from bit 15 down to bit 0.
- R8: Registers 1, 2, 3, 5, 6 and 17 read as 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700.
- R9: Register 0 reads as its stored word with bits 15 and 9 forced to 0 and bit 13 forced to 1.
- R10: A write to a hard-wired register is accepted but does not change what that register reads, and it leaves every other register unchanged.
- R11: After reset, `mdio_out` is 1 and every stored word is 0, so register 0 reads 0x2000 and register 4 reads 0x0000.
- R12: When a frame ends (after the last data bit, or on a rejected start or operation code), the block is back in reset. The next frame may begin on the very next edge without idle bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock line from the host |
| mdio_in | input | 1 | Data line value driven by the host |
| host_drive | input | 1 | 1 when the host drives the data line |
| mdio_out | output | 1 | Current responder bit, valid on the line while the host is not driving |

## Verification
Two functions can fall on the same clock edge. The final data edge of a write commits the word to the table, and on that same edge the tracker drops back to reset and clears its shift registers. A following read must see the committed word and not the cleared shift register. The bench provokes this by sending a write and then, with no idle bits, a read of the same register, and it also runs a read followed at once by a write. It judges the result by the read-back word. A second pairing is a rejected operation code with the start bit of the next frame right behind it; that frame must land in full.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    localparam int unsigned MDIO_DW      = 16;
    localparam int unsigned MDIO_AW      = 5;
    localparam int unsigned MDIO_PHY_AW  = 5;
    localparam int unsigned MDIO_POS_W   = $clog2(MDIO_DW);
    localparam int unsigned MDIO_CNT_W   = 3;

    localparam logic [MDIO_DW-1:0] CTL_FORCE_LOW  = 16'h8200;
    localparam logic [MDIO_DW-1:0] CTL_FORCE_HIGH = 16'h2000;

    typedef enum logic [3:0] {
        FS_RESET  = 4'd0,
        FS_IDLE   = 4'd1,
        FS_START  = 4'd2,
        FS_OPC    = 4'd3,
        FS_OP_HI  = 4'd4,
        FS_OP_LO  = 4'd5,
        FS_PHYADR = 4'd6,
        FS_REGADR = 4'd7,
        FS_TURN1  = 4'd8,
        FS_TURN2  = 4'd9,
        FS_DATA   = 4'd10
    } frame_state_e;

    // Register view seen by a read: hard-wired words win over storage.
    function automatic logic [MDIO_DW-1:0] phy_read_view(
        input logic [MDIO_AW-1:0] idx,
        input logic [MDIO_DW-1:0] stored
    );
        logic [MDIO_DW-1:0] r;
        case (idx)
            5'd0:    r = (stored & ~CTL_FORCE_LOW) | CTL_FORCE_HIGH;
            5'd1:    r = 16'h782C;
            5'd2:    r = 16'h0013;
            5'd3:    r = 16'h61D4;
            5'd5:    r = 16'h41E1;
            5'd6:    r = 16'h0001;
            5'd17:   r = 16'h4700;
            default: r = stored;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdio_sync_edge.sv
module mdio_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    input  logic host_drive,
    output logic edge_o,
    output logic bit_o,
    output logic drive_o
);

    typedef struct packed {
        logic [STAGES-1:0] clk_sh;
        logic [STAGES-1:0] dat_sh;
        logic [STAGES-1:0] drv_sh;
        logic              clk_prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.clk_sh[0] = mdc;
        sy_d.dat_sh[0] = mdio_in;
        sy_d.drv_sh[0] = host_drive;
        for (int i = 1; i < int'(STAGES); i++) begin
            sy_d.clk_sh[i] = sy_q.clk_sh[i-1];
            sy_d.dat_sh[i] = sy_q.dat_sh[i-1];
            sy_d.drv_sh[i] = sy_q.drv_sh[i-1];
        end
        sy_d.clk_prev = sy_q.clk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.clk_sh   <= '0;
            sy_q.dat_sh   <= '1;
            sy_q.drv_sh   <= '0;
            sy_q.clk_prev <= 1'b0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign edge_o  = sy_q.clk_sh[STAGES-1] & ~sy_q.clk_prev;
    assign bit_o   = sy_q.dat_sh[STAGES-1];
    assign drive_o = sy_q.drv_sh[STAGES-1];

    // Two consecutive edge pulses would need the line to rise twice in a row.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R1

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
    import mdio_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [MDIO_AW-1:0] addr_i,
    input  logic [MDIO_DW-1:0] wr_data_i,
    output logic [MDIO_DW-1:0] rd_word_o
);

    localparam int unsigned NUM_REGS = 1 << MDIO_AW;

    logic [MDIO_DW-1:0] mem_d [NUM_REGS];
    logic [MDIO_DW-1:0] mem_q [NUM_REGS];
    logic [MDIO_DW-1:0] view  [NUM_REGS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_REGS); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_view
        assign view[g] = phy_read_view(MDIO_AW'(g), mem_q[g]);
    end

    assign rd_word_o = view[addr_i];

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem_q[$past(addr_i)] == $past(wr_data_i)); // R6

    AST_CTL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == '0) |-> (rd_word_o[15] == 1'b0 && rd_word_o[9] == 1'b0
                            && rd_word_o[13] == 1'b1)); // R9

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_i,
    input  logic               line_bit_i,
    input  logic               drive_i,
    input  logic [MDIO_DW-1:0] rd_word_i,
    output logic [MDIO_AW-1:0] reg_addr_o,
    output logic               wr_en_o,
    output logic [MDIO_DW-1:0] wr_data_o,
    output logic               bit_o
);

    typedef struct packed {
        frame_state_e            state;
        logic                    is_read;
        logic [MDIO_CNT_W-1:0]   cnt;
        logic [MDIO_AW-1:0]      regad;
        logic [MDIO_DW-1:0]      data;
        logic [MDIO_POS_W-1:0]   pos;
        logic                    bitv;
    } fsm_t;

    localparam logic [MDIO_CNT_W-1:0] PHY_LAST = MDIO_CNT_W'(MDIO_PHY_AW - 1);
    localparam logic [MDIO_CNT_W-1:0] REG_LAST = MDIO_CNT_W'(MDIO_AW - 1);
    localparam logic [MDIO_POS_W-1:0] POS_TOP  = MDIO_POS_W'(MDIO_DW - 1);

    fsm_t st_d, st_q;
    logic bit_eff;
    logic wr_fire;
    logic [MDIO_DW-1:0] word_sel;

    assign bit_eff  = drive_i ? line_bit_i : st_q.bitv;
    assign word_sel = (st_q.pos == POS_TOP) ? rd_word_i : st_q.data;

    always_comb begin
        st_d    = st_q;
        wr_fire = 1'b0;
        if (edge_i) begin
            st_d.bitv = bit_eff;
            unique case (st_q.state)
                FS_RESET: begin
                    st_d.cnt   = '0;
                    st_d.regad = '0;
                    st_d.data  = '0;
                    st_d.pos   = POS_TOP;
                    st_d.state = bit_eff ? FS_IDLE : FS_START;
                end
                FS_IDLE: begin
                    st_d.state = bit_eff ? FS_IDLE : FS_START;
                end
                FS_START: begin
                    st_d.state = bit_eff ? FS_OPC : FS_RESET;
                end
                FS_OPC: begin
                    st_d.state = bit_eff ? FS_OP_HI : FS_OP_LO;
                end
                FS_OP_HI: begin
                    if (!bit_eff) begin
                        st_d.is_read = 1'b1;
                        st_d.state   = FS_PHYADR;
                    end else begin
                        st_d.state   = FS_RESET;
                    end
                end
                FS_OP_LO: begin
                    if (bit_eff) begin
                        st_d.is_read = 1'b0;
                        st_d.state   = FS_PHYADR;
                    end else begin
                        st_d.state   = FS_RESET;
                    end
                end
                FS_PHYADR: begin
                    if (st_q.cnt == PHY_LAST) begin
                        st_d.cnt   = '0;
                        st_d.state = FS_REGADR;
                    end else begin
                        st_d.cnt   = st_q.cnt + 1'b1;
                    end
                end
                FS_REGADR: begin
                    st_d.regad = {st_q.regad[MDIO_AW-2:0], bit_eff};
                    if (st_q.cnt == REG_LAST) begin
                        st_d.cnt   = '0;
                        st_d.state = FS_TURN1;
                    end else begin
                        st_d.cnt   = st_q.cnt + 1'b1;
                    end
                end
                FS_TURN1: begin
                    st_d.state = st_q.is_read ? FS_DATA : FS_TURN2;
                end
                FS_TURN2: begin
                    st_d.state = FS_DATA;
                end
                FS_DATA: begin
                    if (st_q.is_read) begin
                        st_d.data = word_sel;
                        st_d.bitv = word_sel[st_q.pos];
                    end else begin
                        st_d.data = st_q.data
                                  | (MDIO_DW'(bit_eff) << st_q.pos);
                    end
                    if (st_q.pos == '0) begin
                        wr_fire    = !st_q.is_read;
                        st_d.state = FS_RESET;
                    end
                    st_d.pos = st_q.pos - 1'b1;
                end
                default: begin
                    st_d.state = FS_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state   <= FS_RESET;
            st_q.is_read <= 1'b0;
            st_q.cnt     <= '0;
            st_q.regad   <= '0;
            st_q.data    <= '0;
            st_q.pos     <= POS_TOP;
            st_q.bitv    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_addr_o = st_q.regad;
    assign wr_en_o    = wr_fire;
    assign wr_data_o  = st_d.data;
    assign bit_o      = st_q.bitv;

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(st_q.state) && $stable(st_q.bitv)); // R1

    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.state == FS_START && !bit_eff)
        |=> st_q.state == FS_RESET); // R3

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && ((st_q.state == FS_OP_HI && bit_eff)
                 || (st_q.state == FS_OP_LO && !bit_eff)))
        |=> st_q.state == FS_RESET); // R4

    AST_FRAME_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.state == FS_DATA && st_q.pos == '0)
        |=> st_q.state == FS_RESET); // R12

    AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (st_q.state == FS_DATA && !st_q.is_read)); // R6

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
    import mdio_resp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    input  logic host_drive,
    output logic mdio_out
);

    logic               edge_s;
    logic               bit_s;
    logic               drive_s;
    logic [MDIO_AW-1:0] reg_addr;
    logic               wr_en;
    logic [MDIO_DW-1:0] wr_data;
    logic [MDIO_DW-1:0] rd_word;

    mdio_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc        (mdc),
        .mdio_in    (mdio_in),
        .host_drive (host_drive),
        .edge_o     (edge_s),
        .bit_o      (bit_s),
        .drive_o    (drive_s)
    );

    mdio_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_s),
        .line_bit_i (bit_s),
        .drive_i    (drive_s),
        .rd_word_i  (rd_word),
        .reg_addr_o (reg_addr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .bit_o      (mdio_out)
    );

    mdio_phy_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (reg_addr),
        .wr_data_i (wr_data),
        .rd_word_o (rd_word)
    );

    AST_OUT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_s |=> $stable(mdio_out)); // R1

endmodule

// File: tb/mdio_responder_tb_top.sv
`timescale 1ns/1ps
module mdio_responder_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdio_in = 1'b1;
    logic host_drive = 1'b0;
    logic mdio_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mdio_responder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc        (mdc),
        .mdio_in    (mdio_in),
        .host_drive (host_drive),
        .mdio_out   (mdio_out)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic edge_bit(input logic b, input logic drv);
        @(negedge clk);
        mdio_in = b;
        host_drive = drv;
        repeat (3) @(negedge clk);
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wiggle(input int n, input logic drv);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_drive = drv;
            mdio_in = ~mdio_in;
        end
    endtask

    task automatic send_field(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            edge_bit(v[i], 1'b1);
        end
    endtask

    task automatic preamble();
        send_field(16'hFFFF, 8);
    endtask

    task automatic wr_frame(input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] dat, input bit pre, input bit wig);
        if (pre) preamble();
        send_field(16'b0101, 4);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, ra}, 5);
        send_field(16'b10, 2);
        for (int i = 15; i >= 0; i--) begin
            edge_bit(dat[i], 1'b1);
            if (wig) wiggle(6, 1'b1);
        end
    endtask

    task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra,
                            output logic [15:0] dat, input bit pre,
                            input bit wig, output bit held);
        logic keep;
        held = 1'b1;
        if (pre) preamble();
        send_field(16'b0110, 4);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, ra}, 5);
        edge_bit(1'b1, 1'b0);
        for (int i = 15; i >= 0; i--) begin
            edge_bit(1'b0, 1'b0);
            dat[i] = mdio_out;
            if (wig) begin
                keep = mdio_out;
                wiggle(6, 1'b1);
                repeat (4) @(negedge clk);
                if (mdio_out !== keep) held = 1'b0;
                host_drive = 1'b0;
            end
        end
    endtask

    task automatic rd_chk(input string req, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] got;
        bit held;
        rd_frame(phy, ra, got, 1'b1, 1'b0, held);
        check(req, got, exp);
    endtask

    // R11: reset state
    task automatic t_reset();
        check("R11 mdio_out after reset", {15'd0, mdio_out}, 16'h0001);
        rd_chk("R11 reg0 reset view", 5'd0, 5'd0, 16'h2000);
        rd_chk("R11 reg4 reset value", 5'd0, 5'd4, 16'h0000);
    endtask

    // R5 R6 R7: write then read, PHY address not decoded
    task automatic t_write_read();
        wr_frame(5'd1, 5'd4, 16'hA5C3, 1'b1, 1'b0);
        rd_chk("R6 R7 reg4 readback", 5'd1, 5'd4, 16'hA5C3);
        rd_chk("R5 reg4 via other PHY address", 5'd30, 5'd4, 16'hA5C3);
        wr_frame(5'd31, 5'd20, 16'h0001, 1'b1, 1'b0);
        rd_chk("R7 reg20 lsb only", 5'd2, 5'd20, 16'h0001);
        rd_chk("R5 reg4 untouched by reg20 write", 5'd0, 5'd4, 16'hA5C3);
    endtask

    // R8: hard-wired identity words
    task automatic t_fixed();
        rd_chk("R8 reg1", 5'd0, 5'd1, 16'h782C);
        rd_chk("R8 reg2", 5'd0, 5'd2, 16'h0013);
        rd_chk("R8 reg3", 5'd0, 5'd3, 16'h61D4);
        rd_chk("R8 reg5", 5'd0, 5'd5, 16'h41E1);
        rd_chk("R8 reg6", 5'd0, 5'd6, 16'h0001);
        rd_chk("R8 reg17", 5'd0, 5'd17, 16'h4700);
    endtask

    // R9: register 0 forced bits
    task automatic t_ctl_reg();
        wr_frame(5'd0, 5'd0, 16'hFFFF, 1'b1, 1'b0);
        rd_chk("R9 reg0 all ones", 5'd0, 5'd0, 16'h7DFF);
        wr_frame(5'd0, 5'd0, 16'h8200, 1'b1, 1'b0);
        rd_chk("R9 reg0 forced-low bits", 5'd0, 5'd0, 16'h2000);
        wr_frame(5'd0, 5'd0, 16'h0041, 1'b1, 1'b0);
        rd_chk("R9 reg0 sparse", 5'd0, 5'd0, 16'h2041);
    endtask

    // R10: writes to hard-wired registers
    task automatic t_fixed_write();
        wr_frame(5'd0, 5'd1, 16'h0000, 1'b1, 1'b0);
        wr_frame(5'd0, 5'd17, 16'hFFFF, 1'b1, 1'b0);
        rd_chk("R10 reg1 after write", 5'd0, 5'd1, 16'h782C);
        rd_chk("R10 reg17 after write", 5'd0, 5'd17, 16'h4700);
        rd_chk("R10 reg4 unaffected", 5'd0, 5'd4, 16'hA5C3);
    endtask

    // R3: bad start pair, then a frame with no idle bits
    task automatic t_bad_start();
        preamble();
        edge_bit(1'b0, 1'b1);
        edge_bit(1'b0, 1'b1);
        wr_frame(5'd0, 5'd7, 16'h1234, 1'b0, 1'b0);
        rd_chk("R3 R12 frame after bad start", 5'd0, 5'd7, 16'h1234);
    endtask

    // R4: rejected opcode pairs
    task automatic t_bad_opcode();
        preamble();
        send_field(16'b0100, 4);
        wr_frame(5'd0, 5'd8, 16'h0F0F, 1'b0, 1'b0);
        rd_chk("R4 frame after opcode 00", 5'd0, 5'd8, 16'h0F0F);
        preamble();
        send_field(16'b0111, 4);
        wr_frame(5'd0, 5'd9, 16'hF00F, 1'b0, 1'b0);
        rd_chk("R4 frame after opcode 11", 5'd0, 5'd9, 16'hF00F);
    endtask

    // R2: line sampled only while host drives
    task automatic t_drive_gate();
        preamble();
        send_field(16'b0101, 4);
        send_field(16'd0, 5);
        send_field(16'd10, 5);
        send_field(16'b10, 2);
        edge_bit(1'b1, 1'b1);
        for (int i = 0; i < 15; i++) edge_bit(1'b0, 1'b0);
        rd_chk("R2 held one bit", 5'd0, 5'd10, 16'hFFFF);
        preamble();
        send_field(16'b0101, 4);
        send_field(16'd0, 5);
        send_field(16'd13, 5);
        send_field(16'b10, 2);
        edge_bit(1'b0, 1'b1);
        for (int i = 0; i < 15; i++) edge_bit(1'b1, 1'b0);
        rd_chk("R2 held zero bit", 5'd0, 5'd13, 16'h0000);
    endtask

    // R1: activity without clock edges
    task automatic t_no_edge();
        logic [15:0] got;
        bit held;
        wr_frame(5'd0, 5'd11, 16'h6A5A, 1'b1, 1'b1);
        rd_frame(5'd0, 5'd11, got, 1'b1, 1'b1, held);
        check("R1 write with data wiggle", got, 16'h6A5A);
        check("R1 mdio_out stable without edge", {15'd0, held}, 16'h0001);
    endtask

    // R12: back-to-back frames without idle bits
    task automatic t_back_to_back();
        logic [15:0] got;
        bit held;
        wr_frame(5'd0, 5'd12, 16'hBEEF, 1'b1, 1'b0);
        rd_frame(5'd0, 5'd12, got, 1'b0, 1'b0, held);
        check("R12 read right after write", got, 16'hBEEF);
        wr_frame(5'd0, 5'd12, 16'h1357, 1'b0, 1'b0);
        rd_frame(5'd0, 5'd12, got, 1'b0, 1'b0, held);
        check("R12 write right after read", got, 16'h1357);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_fixed();
        t_ctl_reg();
        t_fixed_write();
        t_bad_start();
        t_bad_opcode();
        t_drive_gate();
        t_no_edge();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule